// File: doc/BRIEF.md
# Two-CPU Round-Robin Interrupt Aggregator

The block takes a vector of level-style peripheral interrupt status bits and keeps a separate enable bank for each of two processors. A source is pending for a processor when its status bit is high and that processor's enable bit is set. Each processor gets one interrupt line that is high while anything is pending for it. When a processor strobes its service input, the block selects one of its pending sources by fair round-robin and reports it in the next cycle. No source ever outranks another; each processor resumes its search just past the source it was last given.

Software reaches the enable banks and a read-only view of the pending bits through a small word-addressed port. With 64 sources the two 32-bit words appear in reversed order. Two single-cycle operations handle one source at a time. One disables it for both processors. The other enables it only for the processors selected by a two-bit affinity input. An optional cascade maps a contiguous range of source indices onto external interrupt numbers counted from zero, so that external pins routed through the aggregator are reported under their own numbering.

Top module: `irq_rr_agg`

## Requirements
- R1: The pending vector of processor c is the raw status input ANDed with that processor's enable bank. Reading region 2 returns processor 0's pending word and reading region 3 returns processor 1's.
- R2: Line 0 is high exactly when processor 0 has any pending source. Line 1 is high exactly when processor 1 has any pending source and cascading is enabled; otherwise it stays low.
- R3: After reset both enable banks are all zero, both resume pointers are zero, both lines are low and no grant is valid.
- R4: A service strobe on a processor with nothing pending produces no grant: its grant-valid output stays low in the following cycle.
- R5: A strobe with something pending grants the first pending source found from the resume pointer upward, wrapping modulo the source count. The grant-valid output is high for the cycle after the strobe, and the pointer becomes the granted index plus one, modulo the count.
- R6: Each processor has its own resume pointer, and grants to one processor never move the other's pointer.
- R7: The address is {region[1:0], word}. Register word k holds sources 32*(k XOR (W-1)) to 32*(k XOR (W-1))+31, where W is the number of words, with the lowest source in bit 0. Regions 0 and 1 are the enable banks of processors 0 and 1.
- R8: The disable operation clears the selected source's bit in both enable banks.
- R9: The enable operation sets the selected source's bit in bank c when affinity bit c is 1, and clears it when affinity bit c is 0.
- R10: With cascading on, a granted index i with EXT_LO <= i <= EXT_HI is reported as number i-EXT_LO with the external flag set. Any other index is reported unchanged with the flag clear.
- R11: A write to region 0 or 1 replaces the addressed enable word. A write to region 2 or 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src | input | NSRC | Raw peripheral status bits |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address {region, word} |
| wr_data | input | 32 | Write data |
| rd_addr | input | AW | Read address {region, word} |
| rd_data | output | 32 | Read data (combinational) |
| mclr | input | 1 | Disable source op_src in both banks |
| mset | input | 1 | Enable source op_src per op_aff |
| op_src | input | IW | Source index for mclr/mset |
| op_aff | input | 2 | Affinity, bit c selects processor c |
| svc | input | 2 | Service strobe per processor |
| cpu_line | output | 2 | Interrupt line per processor |
| gnt_vld | output | 2 | Grant valid, one cycle after the strobe |
| gnt_ext | output | 2 | Grant lies in the cascaded range |
| gnt_num | output | 2*IW | Reported number, processor c at bits c*IW |

## Verification
The checker watches on every cycle that grant-valid never rises without a preceding strobe and never follows a strobe on an empty pending vector. It also checks that every granted source was pending when it was picked, that disable clears both banks, and that enable follows the affinity bits. Only the bench's scenarios show the round-robin order itself: the wrap past the top index, pointers kept apart between processors, the reversed word layout, the cascade renumbering at both ends of the range, and the writes to read-only regions being dropped.

// File: rtl/irq_rr_agg.sv
module irq_rr_agg #(
  parameter int NSRC    = 64,
  parameter bit CASCADE = 1'b1,
  parameter int EXT_LO  = 24,
  parameter int EXT_HI  = 27,
  localparam int W  = NSRC / 32,
  localparam int IW = $clog2(NSRC),
  localparam int WB = (W > 1) ? $clog2(W) : 1,
  localparam int AW = WB + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [31:0]     wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [31:0]     rd_data,
  input  logic            mclr,
  input  logic            mset,
  input  logic [IW-1:0]   op_src,
  input  logic [1:0]      op_aff,
  input  logic [1:0]      svc,
  output logic [1:0]      cpu_line,
  output logic [1:0]      gnt_vld,
  output logic [1:0]      gnt_ext,
  output logic [2*IW-1:0] gnt_num
);

  logic [1:0][NSRC-1:0] mask_q, mask_d, pend;
  logic [1:0][IW-1:0]   ptr_q, gsrc_q, pick;
  logic [1:0]           hit;

  function automatic int grp(input logic [WB-1:0] w);
    return (W == 1) ? 0 : int'(w ^ WB'(W - 1));
  endfunction

  assign pend[0] = src & mask_q[0];
  assign pend[1] = src & mask_q[1];
  assign cpu_line[0] = |pend[0];
  assign cpu_line[1] = CASCADE & (|pend[1]);

  always_comb begin
    mask_d = mask_q;
    for (int c = 0; c < 2; c++) begin
      if (wr_en && wr_addr[AW-1:WB] == 2'(c))
        mask_d[c][grp(wr_addr[WB-1:0])*32 +: 32] = wr_data;
      if (mclr)      mask_d[c][op_src] = 1'b0;
      else if (mset) mask_d[c][op_src] = op_aff[c];
    end
  end

  always_comb begin
    logic [2*NSRC-1:0] dbl;
    logic [IW-1:0]     off;
    for (int c = 0; c < 2; c++) begin
      dbl = {pend[c], pend[c]} >> ptr_q[c];
      off = '0;
      for (int i = NSRC - 1; i >= 0; i--)
        if (dbl[i]) off = IW'(i);
      pick[c] = ptr_q[c] + off;
      hit[c]  = |pend[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      ptr_q   <= '0;
      gsrc_q  <= '0;
      gnt_vld <= '0;
    end else begin
      mask_q <= mask_d;
      for (int c = 0; c < 2; c++) begin
        gnt_vld[c] <= svc[c] & hit[c];
        if (svc[c] && hit[c]) begin
          gsrc_q[c] <= pick[c];
          ptr_q[c]  <= pick[c] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      gnt_ext[c] = CASCADE && int'(gsrc_q[c]) >= EXT_LO && int'(gsrc_q[c]) <= EXT_HI;
      gnt_num[c*IW +: IW] = gnt_ext[c] ? gsrc_q[c] - IW'(EXT_LO) : gsrc_q[c];
    end
  end

  always_comb begin
    case (rd_addr[AW-1:WB])
      2'd0:    rd_data = mask_q[0][grp(rd_addr[WB-1:0])*32 +: 32];
      2'd1:    rd_data = mask_q[1][grp(rd_addr[WB-1:0])*32 +: 32];
      2'd2:    rd_data = pend[0][grp(rd_addr[WB-1:0])*32 +: 32];
      default: rd_data = pend[1][grp(rd_addr[WB-1:0])*32 +: 32];
    endcase
  end

endmodule

// File: rtl/irq_rr_agg_chk.sv
module irq_rr_agg_chk #(
  parameter int NSRC = 64,
  localparam int IW = $clog2(NSRC)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0][NSRC-1:0] mask_q,
  input logic [1:0][NSRC-1:0] pend,
  input logic [1:0][IW-1:0]   gsrc_q,
  input logic [1:0]           svc,
  input logic [1:0]           gnt_vld,
  input logic                 mclr,
  input logic                 mset,
  input logic [IW-1:0]        op_src,
  input logic [1:0]           op_aff
);

  logic [1:0][NSRC-1:0] pend_prev;
  always_ff @(posedge clk) pend_prev <= pend;

  assert_needs_strobe0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld[0] |-> $past(svc[0]));
  assert_needs_strobe1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld[1] |-> $past(svc[1]));
  assert_empty_no_grant0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (svc[0] && pend[0] == '0) |=> !gnt_vld[0]);
  assert_empty_no_grant1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (svc[1] && pend[1] == '0) |=> !gnt_vld[1]);
  assert_grant_was_pending0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld[0] |-> pend_prev[0][gsrc_q[0]]);
  assert_grant_was_pending1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld[1] |-> pend_prev[1][gsrc_q[1]]);
  assert_clear_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (!mask_q[0][$past(op_src)] && !mask_q[1][$past(op_src)]));
  assert_set_affinity_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mset && !mclr) |=> (mask_q[0][$past(op_src)] == $past(op_aff[0]) &&
                         mask_q[1][$past(op_src)] == $past(op_aff[1])));

endmodule

bind irq_rr_agg irq_rr_agg_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .mask_q(mask_q), .pend(pend), .gsrc_q(gsrc_q),
  .svc(svc), .gnt_vld(gnt_vld), .mclr(mclr), .mset(mset),
  .op_src(op_src), .op_aff(op_aff)
);

// File: tb/irq_rr_agg_tb.sv
`timescale 1ns/1ps
module irq_rr_agg_tb;
  localparam int NSRC = 64;
  localparam int IW = 6;
  localparam int AW = 3;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] src = '0;
  logic wr_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic mclr = 0, mset = 0;
  logic [IW-1:0] op_src = '0;
  logic [1:0] op_aff = '0, svc = '0, cpu_line, gnt_vld, gnt_ext;
  logic [2*IW-1:0] gnt_num;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_rr_agg #(.NSRC(NSRC), .CASCADE(1'b1), .EXT_LO(24), .EXT_HI(27)) u_dut (
    .clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .mclr(mclr),
    .mset(mset), .op_src(op_src), .op_aff(op_aff), .svc(svc),
    .cpu_line(cpu_line), .gnt_vld(gnt_vld), .gnt_ext(gnt_ext), .gnt_num(gnt_num));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] region, input logic word, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = {region, word}; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic reg_rd(input string req, input logic [1:0] region, input logic word,
                        input logic [31:0] exp);
    rd_addr = {region, word};
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic op(input bit clr, input bit set, input int s, input logic [1:0] aff);
    @(negedge clk);
    mclr = clr; mset = set; op_src = IW'(s); op_aff = aff;
    @(negedge clk);
    mclr = 0; mset = 0;
  endtask

  task automatic serve(input string req, input int c, input bit exp_vld,
                       input int exp_num, input bit exp_ext);
    @(negedge clk);
    svc[c] = 1'b1;
    @(negedge clk);
    svc = '0;
    chk(req, gnt_vld[c], exp_vld);
    if (exp_vld) begin
      chk(req, gnt_num[c*IW +: IW], exp_num);
      chk(req, gnt_ext[c], exp_ext);
    end
  endtask

  task automatic t_reset;
    chk("R3 lines", cpu_line, 0);
    chk("R3 valid", gnt_vld, 0);
    reg_rd("R3 bank0 w0", 2'd0, 1'b0, 32'h0);
    reg_rd("R3 bank1 w1", 2'd1, 1'b1, 32'h0);
    src = '1;
    #1 chk("R3 all masked", cpu_line, 0);
    serve("R4 empty strobe", 0, 0, 0, 0);
    serve("R4 empty strobe cpu1", 1, 0, 0, 0);
    src = '0;
  endtask

  task automatic t_layout;
    reg_wr(2'd0, 1'b0, 32'h1);
    src = (64'h1 << 32) | 64'h1;
    reg_rd("R7 bank0 word0 is high half", 2'd0, 1'b0, 32'h1);
    reg_rd("R7 bank0 word1 is low half", 2'd0, 1'b1, 32'h0);
    reg_rd("R1 pending0 word0", 2'd2, 1'b0, 32'h1);
    reg_rd("R1 pending0 word1", 2'd2, 1'b1, 32'h0);
    chk("R2 line0 only", cpu_line, 2'b01);
    reg_wr(2'd2, 1'b0, 32'hFFFF_FFFF);
    reg_wr(2'd3, 1'b1, 32'hFFFF_FFFF);
    reg_rd("R11 bank0 untouched", 2'd0, 1'b0, 32'h1);
    reg_rd("R11 bank1 untouched", 2'd1, 1'b1, 32'h0);
    reg_rd("R11 pending view untouched", 2'd2, 1'b0, 32'h1);
  endtask

  task automatic t_round_robin;
    reg_wr(2'd0, 1'b0, 32'hFFFF_FFFF);
    reg_wr(2'd0, 1'b1, 32'hFFFF_FFFF);
    src = (64'h1 << 3) | (64'h1 << 10) | (64'h1 << 40);
    serve("R5 first", 0, 1, 3, 0);
    serve("R5 second", 0, 1, 10, 0);
    serve("R5 third", 0, 1, 40, 0);
    serve("R5 wrap", 0, 1, 3, 0);
  endtask

  task automatic t_affinity;
    op(0, 1, 3, 2'b10);
    op(0, 1, 10, 2'b10);
    reg_rd("R9 bank0 cleared", 2'd0, 1'b1, 32'hFFFF_FBF7);
    reg_rd("R9 bank1 set", 2'd1, 1'b1, 32'h0000_0408);
    reg_rd("R1 pending1 word1", 2'd3, 1'b1, 32'h0000_0408);
    chk("R2 both lines", cpu_line, 2'b11);
    serve("R6 cpu1 own pointer", 1, 1, 3, 0);
    serve("R6 cpu1 next", 1, 1, 10, 0);
    serve("R6 cpu1 wrap", 1, 1, 3, 0);
    serve("R6 cpu0 unaffected", 0, 1, 40, 0);
  endtask

  task automatic t_clear;
    op(0, 1, 40, 2'b11);
    reg_rd("R9 both set", 2'd1, 1'b0, 32'h100);
    op(1, 0, 40, 2'b11);
    reg_rd("R8 bank0 cleared", 2'd0, 1'b0, 32'hFFFF_FEFF);
    reg_rd("R8 bank1 cleared", 2'd1, 1'b0, 32'h0);
    src = 64'h1 << 40;
    #1 chk("R8 no lines", cpu_line, 2'b00);
  endtask

  task automatic t_cascade;
    op(0, 1, 23, 2'b10);
    op(0, 1, 24, 2'b10);
    op(0, 1, 27, 2'b10);
    op(0, 1, 28, 2'b10);
    src = 64'h1 << 24;
    serve("R10 low edge", 1, 1, 0, 1);
    src = 64'h1 << 27;
    serve("R10 high edge", 1, 1, 3, 1);
    src = 64'h1 << 23;
    serve("R10 below range", 1, 1, 23, 0);
    src = 64'h1 << 28;
    serve("R10 above range", 1, 1, 28, 0);
  endtask

  task automatic t_wrap;
    src = 64'h1 << 63;
    serve("R5 top index", 0, 1, 63, 0);
    src = (64'h1 << 63) | 64'h2;
    serve("R5 after top wraps to 0", 0, 1, 1, 0);
    serve("R5 then top", 0, 1, 63, 0);
  endtask

  task automatic t_line1;
    src = 64'h1 << 3;
    #1 chk("R2 line1 only", cpu_line, 2'b10);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_layout;
    t_round_robin;
    t_affinity;
    t_clear;
    t_cascade;
    t_wrap;
    t_line1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule